// File: doc/BRIEF.md
# Packed Sub-Word Add/Subtract Unit

This unit takes two register-wide operands and treats each as a row of independent 8-bit or 16-bit lanes. It adds or subtracts lane by lane. Each lane can wrap around, halve the full-precision result, or clamp it to the lane's range. Any of these forms can be signed or unsigned. Two crossed forms pair each odd lane with the even lane below it. In these forms one lane of the pair adds and the other subtracts, and each takes its second operand from the partner lane.

The result is registered, so it appears one clock after the request. A per-byte flag vector marks the lanes that clamped on the latest operation, and a sticky copy of those flags collects every clamp since reset. A half-width select limits the operation to the low half of the datapath, which serves narrow operations on a wide machine while keeping the chosen lane width.

Top module: `psimd_addsub`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result`, `sat_lane`, `sat_sticky` and `out_valid` become zero.
- R2: `out_valid` is `in_valid` delayed by one clock. The operation is captured only when `in_valid` is high, and `result` and `sat_lane` hold their values on cycles without a request.
- R3: `width_code` 2'b00 selects 8-bit lanes and 2'b01 selects 16-bit lanes. With `mode_code` 2'b00, op 2'b00 gives a+b and op 2'b01 gives a-b in every lane, modulo the lane width, and no carry or borrow crosses a lane boundary.
- R4: `mode_code` 2'b01 (halving) returns the exact lane sum or difference, computed one bit wider than the lane, shifted right by one and rounded toward minus infinity. It is signed when `is_signed` is 1 and unsigned otherwise.
- R5: `mode_code` 2'b10 with `is_signed` 1 clamps every lane result to the range from the most negative to the most positive lane value, for example 0x80 and 0x7F for 8-bit lanes.
- R6: `mode_code` 2'b10 with `is_signed` 0 clamps every lane result to the range from zero to the all-ones lane value.
- R7: `sat_lane` bit k belongs to byte k of the result. A clamped 8-bit lane k sets bit k, and a clamped 16-bit lane j sets bits 2j and 2j+1. No bit is set outside mode 2'b10 or when no lane clamps.
- R8: `sat_sticky` is the OR of every `sat_lane` value produced since reset. Its bits never clear except by reset.
- R9: op 2'b10 makes each odd lane give a.odd + b.even and each even lane give a.even - b.odd. op 2'b11 makes the odd lane subtract and the even lane add, with the same operand pairing. Both crossed ops use the selected mode.
- R10: With `half_sel` 1, the upper half of `result` and the upper half of `sat_lane` are zero, and the lower half follows R3 to R9.
- R11: `width_code` 2'b10 or 2'b11 yields an all-zero result and no flags.
- R12: `mode_code` 2'b11 behaves exactly as wrapping mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opa | input | XLEN | First operand |
| opb | input | XLEN | Second operand |
| width_code | input | 2 | Lane width: 00 = 8-bit, 01 = 16-bit, 1x reserved |
| op_code | input | 2 | 00 add, 01 sub, 10 crossed add/sub, 11 crossed sub/add |
| mode_code | input | 2 | 00 wrap, 01 halving, 10 saturating, 11 wrap |
| is_signed | input | 1 | Signed lane arithmetic when 1 |
| half_sel | input | 1 | Restrict the operation to the low XLEN/2 bits |
| out_valid | output | 1 | Result valid, one clock after the request |
| result | output | XLEN | Packed lane results |
| sat_lane | output | XLEN/8 | Per-byte clamp flags of the last operation |
| sat_sticky | output | XLEN/8 | Accumulated clamp flags since reset |

## Verification
A fault in the lane extension or in the crossed operand selection shows up at `result` on the clock after the faulty request, and only in the affected lanes. The bench therefore checks every lane of every word against its own lane-by-lane model and does not compare words as plain integers. A clamp flag that is set wrongly stays in `sat_sticky` for the rest of the run, so even a single wrong clamp is still visible in every later check. Carry leaks across lane edges show up in operands that hold all-ones lanes next to small values.

// File: rtl/psimd_pkg.sv
// Shared encodings for the packed add/subtract unit.
// Assumes two-bit operation and mode codes as listed in the brief.
package psimd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_XAS = 2'b10,
        OP_XSA = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        MD_WRAP = 2'b00,
        MD_HALF = 2'b01,
        MD_SAT  = 2'b10,
        MD_RSV  = 2'b11
    } mode_e;

    localparam logic [1:0] WC_B8  = 2'b00;
    localparam logic [1:0] WC_H16 = 2'b01;

    // Decide whether a lane subtracts, given the op and the lane's parity.
    function automatic logic lane_subtracts(op_e op, logic odd_lane);
        case (op)
            OP_SUB:  return 1'b1;
            OP_XAS:  return !odd_lane;
            OP_XSA:  return odd_lane;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/psimd_lane.sv
// One arithmetic lane of width W.
// Extends both operands by two bits, so a single adder result serves wrap,
// halving (shift of a W+1 bit value) and clamp detection. Purely combinational.
module psimd_lane
    import psimd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sgn,
    input  mode_e        mode,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam int XW = W + 2;

    logic [XW-1:0] ea, eb, sum;
    logic          over_hi, over_lo;
    logic [W-1:0]  lim_hi, lim_lo;

    // Extend operands by sign or zero and form the exact sum or difference.
    always_comb begin
        ea  = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
        eb  = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
        sum = sub ? (ea - eb) : (ea + eb);
    end

    // Detect results outside the lane range, and pick the clamp limits.
    always_comb begin
        if (sgn) begin
            over_hi = !sum[W] &&  sum[W-1];
            over_lo =  sum[W] && !sum[W-1];
            lim_hi  = {1'b0, {(W-1){1'b1}}};
            lim_lo  = {1'b1, {(W-1){1'b0}}};
        end else begin
            over_lo = sum[W+1];
            over_hi = !sum[W+1] && sum[W];
            lim_hi  = {W{1'b1}};
            lim_lo  = {W{1'b0}};
        end
    end

    // Choose the lane output for the selected mode.
    always_comb begin
        clamp = 1'b0;
        case (mode)
            MD_HALF: res = sum[W:1];
            MD_SAT: begin
                if (over_hi) begin
                    res   = lim_hi;
                    clamp = 1'b1;
                end else if (over_lo) begin
                    res   = lim_lo;
                    clamp = 1'b1;
                end else begin
                    res   = sum[W-1:0];
                end
            end
            default: res = sum[W-1:0];
        endcase
    end

endmodule

// File: rtl/psimd_lanes.sv
// A row of XLEN/W lanes of one width.
// Does the crossed operand pairing (lane i takes b from lane i^1) and picks
// add or subtract per lane. Assumes XLEN/W is even.
module psimd_lanes
    import psimd_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int W    = 8
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  op_e             op,
    input  mode_e           mode,
    input  logic            sgn,
    output logic [XLEN-1:0] res,
    output logic [XLEN/W-1:0] clamp
);
    localparam int NL = XLEN / W;

    logic crossed;

    // Crossed ops take the second operand from the partner lane.
    always_comb crossed = (op == OP_XAS) || (op == OP_XSA);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int  PARTNER = i ^ 1;
        localparam bit  ODD     = (i % 2) == 1;
        logic [W-1:0] b_pick;
        logic         do_sub;

        // Route the operand and operation for this lane.
        always_comb begin
            b_pick = crossed ? b[PARTNER*W +: W] : b[i*W +: W];
            do_sub = lane_subtracts(op, ODD);
        end

        psimd_lane #(.W(W)) u_lane (
            .a     (a[i*W +: W]),
            .b     (b_pick),
            .sub   (do_sub),
            .sgn   (sgn),
            .mode  (mode),
            .res   (res[i*W +: W]),
            .clamp (clamp[i])
        );
    end

endmodule

// File: rtl/psimd_addsub.sv
// Packed sub-word add/subtract unit with a registered result.
// Both lane rows work in parallel, and the width code selects one of them.
// Half-width operation masks off the upper half. Reserved width codes give zero.
// Synchronous active-low reset.
module psimd_addsub
    import psimd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [1:0]        width_code,
    input  logic [1:0]        op_code,
    input  logic [1:0]        mode_code,
    input  logic              is_signed,
    input  logic              half_sel,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic [XLEN/8-1:0] sat_lane,
    output logic [XLEN/8-1:0] sat_sticky
);
    localparam int NB = XLEN / 8;
    localparam int NH = XLEN / 16;

    op_e              op;
    mode_e            mode;
    logic [XLEN-1:0]  res_b, res_h, res_sel, res_mask, res_nxt;
    logic [NB-1:0]    clp_b, flg_h, flg_sel, flg_mask, flg_nxt;
    logic [NH-1:0]    clp_h;

    // Decode the control codes into the package types.
    always_comb begin
        op   = op_e'(op_code);
        mode = mode_e'(mode_code);
    end

    psimd_lanes #(.XLEN(XLEN), .W(8)) u_bytes (
        .a(opa), .b(opb), .op(op), .mode(mode), .sgn(is_signed),
        .res(res_b), .clamp(clp_b)
    );

    psimd_lanes #(.XLEN(XLEN), .W(16)) u_halves (
        .a(opa), .b(opb), .op(op), .mode(mode), .sgn(is_signed),
        .res(res_h), .clamp(clp_h)
    );

    // Spread each 16-bit lane's clamp flag over its two byte positions.
    for (genvar j = 0; j < NH; j++) begin : g_hflag
        always_comb flg_h[2*j +: 2] = {2{clp_h[j]}};
    end

    // Select the lane row by width code and apply the half-width mask.
    always_comb begin
        res_mask = half_sel ? {{(XLEN/2){1'b0}}, {(XLEN/2){1'b1}}} : {XLEN{1'b1}};
        flg_mask = half_sel ? {{(NB/2){1'b0}}, {(NB/2){1'b1}}}     : {NB{1'b1}};
        case (width_code)
            WC_B8: begin
                res_sel = res_b;
                flg_sel = clp_b;
            end
            WC_H16: begin
                res_sel = res_h;
                flg_sel = flg_h;
            end
            default: begin
                res_sel = '0;
                flg_sel = '0;
            end
        endcase
        res_nxt = res_sel & res_mask;
        flg_nxt = flg_sel & flg_mask;
    end

    // Register the result and flags, and accumulate the sticky clamp record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            sat_lane   <= '0;
            sat_sticky <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= res_nxt;
                sat_lane   <= flg_nxt;
                sat_sticky <= sat_sticky | flg_nxt;
            end
        end
    end

endmodule

// File: rtl/psimd_addsub_chk.sv
// Port-level properties of psimd_addsub, attached by bind.
// Assumes the registered timing of one clock from request to result.
module psimd_addsub_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        width_code,
    input logic [1:0]        mode_code,
    input logic              half_sel,
    input logic              out_valid,
    input logic [XLEN-1:0]   result,
    input logic [XLEN/8-1:0] sat_lane,
    input logic [XLEN/8-1:0] sat_sticky
);
    localparam int NB = XLEN / 8;

    // R1: reset clears the outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && sat_sticky == '0 && sat_lane == '0));

    // R2: valid follows the request by one clock
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(sat_lane)));

    // R7: flags only in saturating mode
    a_r7_flags_need_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_code != 2'b10) |=> sat_lane == '0);

    // R8: sticky holds the current flags and never loses a bit
    a_r8_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_lane & ~sat_sticky) == '0);
    a_r8_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sat_sticky & $past(sat_sticky)) == $past(sat_sticky)));

    // R10: half-width leaves the upper half empty
    a_r10_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_sel) |=> (result[XLEN-1:XLEN/2] == '0 && sat_lane[NB-1:NB/2] == '0));

    // R11: reserved width codes give nothing
    a_r11_reserved_width: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_code[1]) |=> (result == '0 && sat_lane == '0));

endmodule

bind psimd_addsub psimd_addsub_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .width_code (width_code),
    .mode_code  (mode_code),
    .half_sel   (half_sel),
    .out_valid  (out_valid),
    .result     (result),
    .sat_lane   (sat_lane),
    .sat_sticky (sat_sticky)
);

// File: tb/tb_psimd_addsub.sv
// Directed bench for psimd_addsub: one task per scenario plus a random sweep
// against a lane-by-lane integer model written from the requirements.
module tb_psimd_addsub;
    localparam int XLEN = 64;
    localparam int NB   = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [XLEN-1:0] opa, opb;
    logic [1:0]      width_code, op_code, mode_code;
    logic            is_signed, half_sel;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic [NB-1:0]   sat_lane, sat_sticky;

    int checks = 0;
    int errors = 0;
    logic [NB-1:0] exp_sticky;

    always #5 clk = ~clk;

    psimd_addsub #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opa(opa), .opb(opb), .width_code(width_code), .op_code(op_code),
        .mode_code(mode_code), .is_signed(is_signed), .half_sel(half_sel),
        .out_valid(out_valid), .result(result), .sat_lane(sat_lane),
        .sat_sticky(sat_sticky)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Lane value from a word, as a signed or unsigned integer.
    function automatic int lane_val(input logic [XLEN-1:0] x, input int i, input int w, input logic sg);
        int v;
        v = 0;
        for (int k = 0; k < w; k++) v[k] = x[i*w+k];
        if (sg && x[i*w+w-1]) v = v - (1 << w);
        return v;
    endfunction

    // Reference model written from the requirements.
    function automatic void model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                  input logic [1:0] wc, input logic [1:0] op, input logic [1:0] md,
                                  input logic sg, input logic hf,
                                  output logic [XLEN-1:0] r, output logic [NB-1:0] f);
        int w, n;
        r = '0;
        f = '0;
        if (wc[1]) return;
        w = wc[0] ? 16 : 8;
        n = XLEN / w;
        for (int i = 0; i < n; i++) begin
            int j, x, y, s, lo, hi;
            bit sb, cl;
            if (hf && i*w >= XLEN/2) continue;
            j  = (op >= 2) ? (i ^ 1) : i;
            sb = (op == 1) || (op == 2 && i % 2 == 0) || (op == 3 && i % 2 == 1);
            x  = lane_val(a, i, w, sg);
            y  = lane_val(b, j, w, sg);
            s  = sb ? x - y : x + y;
            lo = sg ? -(1 << (w-1)) : 0;
            hi = sg ? (1 << (w-1)) - 1 : (1 << w) - 1;
            cl = 1'b0;
            if (md == 2'b01) s = s >>> 1;
            else if (md == 2'b10) begin
                if (s > hi) begin s = hi; cl = 1'b1; end
                else if (s < lo) begin s = lo; cl = 1'b1; end
            end
            for (int k = 0; k < w; k++) r[i*w+k] = s[k];
            if (cl) for (int k = 0; k < w/8; k++) f[i*(w/8)+k] = 1'b1;
        end
    endfunction

    // Drive one request, sample one clock later, and compare with the model.
    task automatic run(input string tag, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [1:0] wc, input logic [1:0] op, input logic [1:0] md,
                       input logic sg, input logic hf);
        logic [XLEN-1:0] er;
        logic [NB-1:0]   ef;
        model(a, b, wc, op, md, sg, hf, er, ef);
        exp_sticky = exp_sticky | ef;
        @(negedge clk);
        opa = a; opb = b; width_code = wc; op_code = op; mode_code = md;
        is_signed = sg; half_sel = hf; in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " valid R2"}, {63'b0, out_valid}, 64'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " flags R7"}, {56'b0, sat_lane}, {56'b0, ef});
        chk({tag, " sticky R8"}, {56'b0, sat_sticky}, {56'b0, exp_sticky});
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; opa = '0; opb = '0; width_code = '0;
        op_code = '0; mode_code = '0; is_signed = 1'b0; half_sel = 1'b0;
        exp_sticky = '0;
        repeat (3) @(negedge clk);
        chk("R1 result", result, '0);
        chk("R1 valid", {63'b0, out_valid}, '0);
        chk("R1 sticky", {56'b0, sat_sticky}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_plain();
        run("R3 add8 no carry", 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_0001, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
        chk("R3 add8 fixed", result, 64'h0000_0000_0000_0100);
        run("R3 sub16 borrow", 64'h0001_0000_0005_0000, 64'h0000_0001_0001_0001, 2'b01, 2'b01, 2'b00, 1'b1, 1'b0);
        chk("R3 sub16 fixed", result, 64'h0001_FFFF_0004_FFFF);
    endtask

    task automatic t_halving();
        run("R4 uhalf8", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00FF, 2'b00, 2'b00, 2'b01, 1'b0, 1'b0);
        chk("R4 uhalf8 fixed", result, 64'h0000_0000_0000_00FF);
        run("R4 shalf16", 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 2'b01, 2'b00, 2'b01, 1'b1, 1'b0);
        chk("R4 shalf16 fixed", result, 64'h0000_0000_0000_8000);
        run("R4 usub half", 64'h0, 64'h0000_0000_0000_0001, 2'b00, 2'b01, 2'b01, 1'b0, 1'b0);
        chk("R4 usub half fixed", result, 64'h0000_0000_0000_00FF);
    endtask

    task automatic t_saturate();
        run("R5 ssat8 hi", 64'h0000_0000_0000_007F, 64'h0000_0000_0000_0001, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0);
        chk("R5 ssat8 hi fixed", result, 64'h0000_0000_0000_007F);
        chk("R7 ssat8 flag", {56'b0, sat_lane}, 64'h01);
        run("R5 ssat8 lo", 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0100, 2'b00, 2'b01, 2'b10, 1'b1, 1'b0);
        chk("R5 ssat8 lo fixed", result, 64'h0000_0000_0000_8000);
        run("R6 usat16 hi", 64'h0000_0000_FFFF_0000, 64'h0000_0000_0001_0000, 2'b01, 2'b00, 2'b10, 1'b0, 1'b0);
        chk("R6 usat16 hi fixed", result, 64'h0000_0000_FFFF_0000);
        chk("R7 usat16 flags", {56'b0, sat_lane}, 64'h0C);
        run("R6 usat8 lo", 64'h0, 64'h0000_0000_0000_0001, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0);
        chk("R6 usat8 lo fixed", result, 64'h0);
    endtask

    task automatic t_sticky_hold();
        run("R8 after wrap", 64'h1, 64'h1, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0);
        chk("R8 sticky kept", {56'b0, sat_sticky}, 64'h0F);
        @(negedge clk);
        opa = 64'hFFFF; opb = 64'hFFFF; op_code = 2'b01;
        @(negedge clk);
        chk("R2 idle valid low", {63'b0, out_valid}, '0);
        chk("R2 idle result held", result, 64'h2);
    endtask

    task automatic t_cross();
        run("R9 xas16", 64'h0000_0000_0005_000A, 64'h0000_0000_0003_0002, 2'b01, 2'b10, 2'b00, 1'b0, 1'b0);
        chk("R9 xas16 fixed", result, 64'h0000_0000_0007_0007);
        run("R9 xsa16", 64'h0000_0000_0005_000A, 64'h0000_0000_0003_0002, 2'b01, 2'b11, 2'b00, 1'b0, 1'b0);
        chk("R9 xsa16 fixed", result, 64'h0000_0000_0003_000D);
        run("R9 xas16 sat", 64'h7FFF_8000_0000_0000, 64'h0001_7FFF_0000_0000, 2'b01, 2'b10, 2'b10, 1'b1, 1'b0);
    endtask

    task automatic t_misc();
        run("R10 half", 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1);
        chk("R10 half fixed", result, 64'h0000_0000_0202_0202);
        run("R11 reserved width", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'b10, 2'b00, 2'b10, 1'b1, 1'b0);
        chk("R11 zero", result, 64'h0);
        run("R12 mode3 wraps", 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b00, 2'b00, 2'b11, 1'b0, 1'b0);
        chk("R12 fixed", result, 64'h0);
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 400; n++) begin
            logic [XLEN-1:0] a, b;
            logic [1:0] wc, op, md;
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if (n % 4 == 0) b = ~a;
            wc = (n % 16 == 15) ? 2'b10 : {1'b0, n[0]};
            op = n[2:1];
            md = n[4:3];
            run("R3 R4 R5 R6 R9 sweep", a, b, wc, op, md, n[5], n[6] & n[7]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_plain();
        t_halving();
        t_saturate();
        t_sticky_hold();
        t_cross();
        t_misc();
        t_sweep();
        summary();
    end

endmodule